// File: doc/BRIEF.md
# ADC Sample FIFO with Status

This block buffers conversion results between an analog-to-digital conversion engine and a byte-wide host bus. Each result arrives as a 16-bit word. The low four bits carry the channel number and the upper twelve bits carry the sample code. Up to 1024 words are held in arrival order. The host takes each word as two byte reads: the low byte first, then the high byte. Reading the high byte removes the word.

A status byte reports three flags: empty, half full and a latched overflow. The host enables and disables the FIFO, empties it and acknowledges its interrupt, each by writing to its own address. An interrupt is raised when the fill level climbs to half the depth. The host's service routine can then drain exactly 512 words per interrupt without testing the status between reads. The normal shutdown writes the interrupt clear, then the flush, then the disable.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the FIFO is disabled and empty, overflow is clear, `irq` is low, and a status read returns 0x01.
- R2: An accepted sample is stored as {code[11:0], chan[3:0]}. Words leave in arrival order. A read of address 0 returns bits 7:0 of the oldest word, and a read of address 1 returns bits 15:8. Read data appears on `host_rdata` one clock after the read strobe and holds until the next read.
- R3: A read of address 0 leaves the FIFO unchanged. A read of address 1 removes the oldest word. A read of address 1 while the FIFO is empty changes nothing.
- R4: A read of address 2 returns the status byte: bit 0 = empty, bit 1 = fill level of at least 512, bit 2 = overflow, bits 7:3 = 0. A read of any address from 3 to 7 returns 0.
- R5: A write to address 3 enables the FIFO when bit 0 of the write data is 1 and disables it when that bit is 0. While the FIFO is disabled, incoming samples are discarded and neither the status nor `irq` changes.
- R6: A sample that arrives while 1024 words are stored, with no word removed in the same cycle, is dropped and sets the overflow flag. The flag stays set until a flush.
- R7: A write of any value to address 4 empties the FIFO and clears overflow. In that cycle the flush takes precedence over an arriving sample and over a removal.
- R8: `irq` goes high in the cycle the fill level rises from 511 to 512. It stays high until cleared, whether or not the level later falls or the FIFO is flushed. Staying at or above 512 does not raise it again, but each new rise from 511 to 512 does.
- R9: A write to address 5 drops `irq`. If a rise to 512 happens in the same cycle, `irq` stays high.
- R10: The shutdown sequence (write 5, write 4, write 3 with 0) leaves `irq` low and the status at 0x01. Samples that arrive afterwards are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe from the converter, one word per cycle |
| smp_chan | input | 4 | Channel number of the sample |
| smp_code | input | 12 | Conversion code of the sample |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Pending half-full interrupt |

## Verification
The bench fills the FIFO to exactly 1024 words and pushes one more with a distinct value. A design that overwrote the head or advanced the pointers would then return a corrupted word during the drain. It checks that `irq` is still low at 511 words, high at 512, and high again after the level dips to 511 and returns. An edge detector that lagged or fired on the level would fail one of those three checks. It reads the low byte twice before the high byte, reads the high byte while the FIFO is empty, and flushes in the same cycle as an arriving sample. A design that popped on the low byte, underflowed, or let the sample win over the flush would misreport the status or the next word. A seeded random mix of pushes, word reads, enable toggles and interrupt clears checks every word and status byte against a queue model.

// File: rtl/adc_fifo_pkg.sv
// Shared definitions for the ADC sample FIFO: host register addresses
// and status bit positions. Assumes a 3-bit host address.
package adc_fifo_pkg;

    typedef enum logic [2:0] {
        ADR_DATA_LO = 3'd0,
        ADR_DATA_HI = 3'd1,
        ADR_STATUS  = 3'd2,
        ADR_ENABLE  = 3'd3,
        ADR_FLUSH   = 3'd4,
        ADR_IRQ_CLR = 3'd5
    } fifo_reg_e;

    localparam int ST_EMPTY = 0;
    localparam int ST_HALF  = 1;
    localparam int ST_OVF   = 2;

endpackage

// File: rtl/fifo_store.sv
// Word storage with read/write pointers and an occupancy count.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
// Flush overrides push and pop. A push while full is accepted only when
// a pop happens in the same cycle; otherwise the push is flagged as dropped.
module fifo_store #(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              empty,
    output logic              dropped,
    output logic              cross_up
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count_next;
    logic              full, push_do, pop_do;

    // Qualify requests against occupancy and flush.
    always_comb begin
        full       = (count == FULL_C);
        empty      = (count == '0);
        pop_do     = pop && !empty && !flush;
        push_do    = push && !flush && (!full || pop_do);
        dropped    = push && !flush && full && !pop_do;
        count_next = flush ? '0 : count + CW'(push_do) - CW'(pop_do);
        cross_up   = !flush && (count < HALF_C) && (count_next >= HALF_C);
    end

    // Storage array, no reset needed.
    always_ff @(posedge clk) begin
        if (push_do) mem[wr_ptr] <= din;
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_do) wr_ptr <= wr_ptr + AW'(1);
            if (pop_do)  rd_ptr <= rd_ptr + AW'(1);
            count <= count_next;
        end
    end

    assign head = mem[rd_ptr];

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> (count == FULL_C));
    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (count == '0));

endmodule

// File: rtl/fifo_flags.sv
// Sticky overflow flag and the half-full interrupt latch.
// Assumes cross_up pulses for one cycle when the level rises to half depth.
// A rise in the same cycle as a clear keeps the interrupt pending.
module fifo_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic dropped,
    input  logic cross_up,
    input  logic irq_clr,
    input  logic half,
    output logic ovf,
    output logic irq
);
    // Overflow latch, cleared only by flush.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (flush)   ovf <= 1'b0;
        else if (dropped) ovf <= 1'b1;
    end

    // Interrupt latch: set on the rise to half, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (cross_up) irq <= 1'b1;
        else if (irq_clr)  irq <= 1'b0;
    end

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);
    // R7
    flush_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ovf);
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> half);
    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !cross_up) |=> !irq);

endmodule

// File: rtl/fifo_host_port.sv
// Byte-wide host register port: decodes the command writes, holds the
// enable bit and registers read data one cycle after the read strobe.
// Assumes single-cycle read and write strobes that are never both high.
module fifo_host_port
    import adc_fifo_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    input  logic [WORD_W-1:0] head,
    input  logic [7:0]        status,
    output logic [7:0]        host_rdata,
    output logic              enable,
    output logic              flush_req,
    output logic              clr_req,
    output logic              pop_req
);
    fifo_reg_e  sel;
    logic [7:0] rd_mux;

    // Address decode for the command strobes.
    always_comb begin
        sel       = fifo_reg_e'(host_addr);
        flush_req = host_wr && (sel == ADR_FLUSH);
        clr_req   = host_wr && (sel == ADR_IRQ_CLR);
        pop_req   = host_rd && (sel == ADR_DATA_HI);
    end

    // Read data selection.
    always_comb begin
        case (sel)
            ADR_DATA_LO: rd_mux = head[7:0];
            ADR_DATA_HI: rd_mux = head[15:8];
            ADR_STATUS:  rd_mux = status;
            default:     rd_mux = 8'h00;
        endcase
    end

    // Enable register and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable     <= 1'b0;
            host_rdata <= 8'h00;
        end else begin
            if (host_wr && (sel == ADR_ENABLE)) enable <= host_wdata[0];
            if (host_rd) host_rdata <= rd_mux;
        end
    end

    // R5
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd3) |=> (enable == $past(host_wdata[0])));
    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

endmodule

// File: rtl/adc_sample_fifo.sv
// Top of the ADC sample FIFO. Packs tagged samples into words, stores them,
// and exposes byte reads, a status byte and a half-full interrupt.
// Assumes at most one sample per cycle and a word size of 16 bits.
module adc_sample_fifo
    import adc_fifo_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int CHAN_W = 4,
    parameter int CODE_W = 12,
    localparam int WORD_W = CHAN_W + CODE_W,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [CODE_W-1:0] smp_code,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq
);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    logic [WORD_W-1:0] head;
    logic [CW-1:0]     count;
    logic [7:0]        status;
    logic enable, flush_req, clr_req, pop_req;
    logic empty, dropped, cross_up, half, ovf, push;

    // Gate samples with the enable and form the status byte.
    always_comb begin
        push   = smp_valid && enable;
        half   = (count >= HALF_C);
        status = 8'h00;
        status[ST_EMPTY] = empty;
        status[ST_HALF]  = half;
        status[ST_OVF]   = ovf;
    end

    fifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop_req), .flush(flush_req),
        .din({smp_code, smp_chan}), .head(head), .count(count), .empty(empty),
        .dropped(dropped), .cross_up(cross_up)
    );

    fifo_flags u_flags (
        .clk(clk), .rst_n(rst_n), .flush(flush_req), .dropped(dropped),
        .cross_up(cross_up), .irq_clr(clr_req), .half(half), .ovf(ovf), .irq(irq)
    );

    fifo_host_port #(.WORD_W(WORD_W)) u_port (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .head(head), .status(status),
        .host_rdata(host_rdata), .enable(enable), .flush_req(flush_req),
        .clr_req(clr_req), .pop_req(pop_req)
    );

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !host_wr && !host_rd) |=> ($stable(count) && $stable(ovf) && $stable(irq)));

endmodule

// File: tb/tb_adc_sample_fifo.sv
module tb_adc_sample_fifo;
    localparam int DEPTH = 1024;
    localparam int HALF  = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [3:0]  smp_chan = '0;
    logic [11:0] smp_code = '0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [15:0] mq[$];
    bit m_en = 1'b0, m_ovf = 1'b0, m_irq = 1'b0;

    always #5 clk = ~clk;

    adc_sample_fifo dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_code(smp_code), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    function automatic logic [7:0] exp_status();
        return {5'b0, m_ovf, (mq.size() >= HALF), (mq.size() == 0)};
    endfunction

    function automatic logic [15:0] mk_word(input logic [3:0] ch, input logic [11:0] code);
        return {code, ch};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_smp(input logic [3:0] ch, input logic [11:0] code);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = ch; smp_code = code;
        @(negedge clk);
        smp_valid = 1'b0;
        if (m_en) begin
            if (mq.size() < DEPTH) begin
                mq.push_back(mk_word(ch, code));
                if (mq.size() == HALF) m_irq = 1'b1;
            end else m_ovf = 1'b1;
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        case (a)
            3'd3: m_en = d[0];
            3'd4: begin mq.delete(); m_ovf = 1'b0; end
            3'd5: m_irq = 1'b0;
            default: ;
        endcase
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic chk_status(input string req);
        logic [7:0] s;
        host_read(3'd2, s);
        check(req, {8'h0, s}, {8'h0, exp_status()});
        check(req, {15'h0, irq}, {15'h0, m_irq});
    endtask

    task automatic read_word(input string req);
        logic [7:0] lo, hi;
        logic [15:0] e;
        host_read(3'd0, lo);
        host_read(3'd1, hi);
        e = mq.pop_front();
        check(req, {hi, lo}, e);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_status("R1");
        host_read(3'd6, b);
        check("R4 unused address", {8'h0, b}, 16'h0);

        // R5: disabled FIFO ignores samples
        push_smp(4'h3, 12'hABC);
        push_smp(4'h4, 12'h123);
        chk_status("R5 disabled");

        // R3: low read is non-destructive, high read pops
        host_write(3'd3, 8'h01);
        push_smp(4'h7, 12'h5A5);
        host_read(3'd0, b);
        host_read(3'd0, b);
        check("R3 low read", {8'h0, b}, 16'h0057);
        chk_status("R3 after low reads");
        host_read(3'd1, b);
        check("R2 high byte", {8'h0, b}, 16'h005A);
        void'(mq.pop_front());
        chk_status("R3 after pop");
        host_read(3'd1, b);
        chk_status("R3 empty pop");
        push_smp(4'h1, 12'h321);
        read_word("R3 pointer after empty pop");

        // R7: flush wins over a same-cycle sample
        push_smp(4'h2, 12'h222);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 4'h9; smp_code = 12'h999;
        host_wr = 1'b1; host_addr = 3'd4; host_wdata = 8'h5C;
        @(negedge clk);
        smp_valid = 1'b0; host_wr = 1'b0;
        mq.delete(); m_ovf = 1'b0;
        chk_status("R7 flush vs push");

        // R8, R6: fill across the half mark and past full
        for (int i = 0; i < HALF - 1; i++) push_smp(4'(i), 12'(i * 7));
        check("R8 no irq at 511", {15'h0, irq}, 16'h0);
        push_smp(4'hF, 12'hF0F);
        check("R8 irq at 512", {15'h0, irq}, 16'h1);
        chk_status("R4 half");
        host_write(3'd5, 8'h00);
        check("R9 irq cleared", {15'h0, irq}, 16'h0);
        for (int i = HALF; i < DEPTH; i++) push_smp(4'(i), 12'(i * 3));
        check("R8 no re-raise above half", {15'h0, irq}, 16'h0);
        push_smp(4'hE, 12'hEEE);
        chk_status("R6 overflow set");
        for (int i = 0; i < HALF; i++) read_word("R2 drain order");
        chk_status("R6 overflow sticky at 512");
        read_word("R2 drain");
        chk_status("R6 overflow sticky at 511");
        push_smp(4'hC, 12'hCCC);
        check("R8 irq re-raised", {15'h0, irq}, 16'h1);
        host_write(3'd4, 8'hFF);
        chk_status("R7 flush clears, irq kept");

        // Random mix against the model
        for (int it = 0; it < 2000; it++) begin
            int r;
            r = int'($urandom % 16);
            if (r <= 8) push_smp(4'($urandom), 12'($urandom));
            else if (r <= 12) begin
                if (mq.size() != 0) read_word("R2 random");
                else chk_status("R4 random empty");
            end else if (r == 13) chk_status("R4 random");
            else if (r == 14) begin
                if ($urandom % 4 == 0) host_write(3'd3, {7'h0, !m_en});
            end else host_write(3'd5, 8'h00);
        end
        chk_status("R4 after random");
        while (mq.size() != 0) read_word("R2 final drain");

        // R10: shutdown sequence
        host_write(3'd3, 8'h01);
        for (int i = 0; i < HALF; i++) push_smp(4'h5, 12'(i));
        host_write(3'd5, 8'h00);
        host_write(3'd4, 8'h00);
        host_write(3'd3, 8'h00);
        chk_status("R10 shutdown");
        push_smp(4'h6, 12'h666);
        chk_status("R10 ignored after shutdown");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule